// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. Software writes a byte into a holding register. The transmitter moves that byte into an internal shift register and then serialises it as a frame. The frame is a low start bit, eight data bits sent least significant bit first, an optional even or odd parity bit, and a high stop bit. Each bit on the line lasts exactly one period of an externally supplied baud tick.

The holding register and the shift register are separate, so software can queue the next byte while the current frame is still on the wire. The transmitter checks for a queued byte on the tick that starts the stop bit. If a byte is waiting, it is loaded at that moment and its start bit follows the stop bit with no idle period in between. If nothing is waiting, a transmission-end flag is raised and the line rests high after the stop bit.

Two status flags are visible at the ports: holding register empty and transmission ended. Each flag has a matching interrupt request, which is asserted while the flag and its enable are both high.

Top module: `dbuf_serial_tx`

## Requirements
- R1: While `en` is 0 (and after reset), `tx_out`, `hold_empty` and `tx_done` are all 1, and `wr_en` pulses have no effect: no frame follows when the block is enabled again.
- R2: A write (`wr_en`=1 while `en`=1) clears both `hold_empty` and `tx_done` in the cycle after the write edge.
- R3: A frame is a 0 start bit, then `wr_data[0]` through `wr_data[7]` in that order, an optional parity bit, and a 1 stop bit. `tx_out` changes only on a clock edge where `baud_tick` was 1 (or `en` was 0), so each bit lasts one tick period.
- R4: When idle with a byte pending, the byte is moved to the shift register on the next `baud_tick`. `hold_empty` returns to 1 on that same edge, and the start bit begins.
- R5: With `par_en`=1 a parity bit follows D7. With `par_odd`=0 the parity bit equals the XOR of the 8 data bits (even parity); with `par_odd`=1 it is the inverse (odd parity). Both settings are captured when the byte is loaded into the shift register.
- R6: If a byte is pending on the tick that starts the stop bit, it is loaded then. Its start bit comes on the very next tick after the stop bit, with zero idle bits in between, and `tx_done` stays 0.
- R7: If no byte is pending on the tick that starts the stop bit, `tx_done` becomes 1 on that edge, and `tx_out` then stays 1 until new data arrives.
- R8: `irq_empty` is 1 exactly while `hold_empty` and `txi_en` are both 1. `irq_done` is 1 exactly while `tx_done` and `tei_en` are both 1.
- R9: A write while a byte is already pending replaces that pending byte and leaves `hold_empty` at 0. The frame being shifted is not altered, and the replaced byte is never sent.
- R10: Dropping `en` in the middle of a frame aborts it: `tx_out` is 1 from the next cycle on, and the pending byte is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Transmitter enable |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte written into the holding register |
| par_en | input | 1 | Send a parity bit after the data |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| txi_en | input | 1 | Enable for the holding-register-empty interrupt |
| tei_en | input | 1 | Enable for the transmission-end interrupt |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| tx_out | output | 1 | Serial output line, idles at 1 |
| hold_empty | output | 1 | Holding register has no pending byte |
| tx_done | output | 1 | Last frame finished with no byte queued |
| irq_empty | output | 1 | Holding-register-empty interrupt request |
| irq_done | output | 1 | Transmission-end interrupt request |

## Verification
The hardest situation to reach from the ports is a byte becoming pending before the stop bit starts, with nothing yet sent in the gap. This is needed both for gapless chaining and for replacing a pending byte. The stimulus waits for `hold_empty` to rise, which shows that the previous byte has just entered the shift register. It then writes during the roughly ten tick periods that remain before the stop bit. A bit-level monitor counts the idle bits before each frame and requires zero for chained frames. For the replacement case, the scoreboard entry of the replaced byte is overwritten, so any transmission of that byte is reported as a mismatch.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;

  typedef enum logic [2:0] {
    ST_MARK   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4
  } tx_state_e;

endpackage

// File: rtl/dbtx_parity.sv
module dbtx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              odd,
  output logic              par_bit
);
  // XOR chain across the data bits; the chain is seeded with the mode so
  // odd parity comes out inverted.
  logic [DATA_W:0] chain;

  assign chain[0] = odd;

  for (genvar i = 0; i < DATA_W; i++) begin : g_xor
    assign chain[i+1] = chain[i] ^ data[i];
  end

  assign par_bit = chain[DATA_W];
endmodule

// File: rtl/dbtx_holding.sv
module dbtx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  input  logic              end_set,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_empty,
  output logic              tx_done
);
  logic [DATA_W-1:0] data_q;
  logic              empty_q, empty_d;
  logic              done_q, done_d;
  logic              wr_ok;

  assign wr_ok = en & wr_en;

  // Flag next-state. A write beats a same-cycle take: the shifter keeps
  // the old byte and the new one stays pending.
  always_comb begin
    empty_d = empty_q;
    done_d  = done_q;
    if (!en) begin
      empty_d = 1'b1;
      done_d  = 1'b1;
    end else begin
      if (wr_ok) begin
        empty_d = 1'b0;
      end else if (take) begin
        empty_d = 1'b1;
      end
      if (wr_ok) begin
        done_d = 1'b0;
      end else if (end_set) begin
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      done_q  <= 1'b1;
    end else begin
      empty_q <= empty_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (wr_ok) begin
      data_q <= wr_data;
    end
  end

  assign hold_data  = data_q;
  assign hold_empty = empty_q;
  assign tx_done    = done_q;
endmodule

// File: rtl/dbtx_shifter.sv
module dbtx_shifter
  import dbtx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              baud_tick,
  input  logic              pending,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              take,
  output logic              end_set,
  output logic              tx_out
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic              pen_q, pen_d;
  logic              chain_q, chain_d;
  logic              out_q, out_d;
  logic              load, stop_entry, upd;
  logic              par_calc;

  dbtx_parity #(.DATA_W(DATA_W)) u_par (
    .data    (hold_data),
    .odd     (par_odd),
    .par_bit (par_calc)
  );

  assign upd = ~en | baud_tick;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    par_d      = par_q;
    pen_d      = pen_q;
    chain_d    = chain_q;
    load       = 1'b0;
    stop_entry = 1'b0;
    end_set    = 1'b0;

    if (!en) begin
      state_d = ST_MARK;
      chain_d = 1'b0;
    end else if (baud_tick) begin
      unique case (state_q)
        ST_MARK: begin
          if (pending) begin
            load    = 1'b1;
            state_d = ST_START;
          end
        end
        ST_START: begin
          state_d = ST_DATA;
          cnt_d   = '0;
        end
        ST_DATA: begin
          sh_d = sh_q >> 1;
          if (cnt_q == LAST_BIT) begin
            if (pen_q) state_d = ST_PARITY;
            else       stop_entry = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_PARITY: begin
          stop_entry = 1'b1;
        end
        ST_STOP: begin
          chain_d = 1'b0;
          if (chain_q) begin
            state_d = ST_START;
          end else if (pending) begin
            load    = 1'b1;
            state_d = ST_START;
          end else begin
            state_d = ST_MARK;
          end
        end
        default: state_d = ST_MARK;
      endcase

      // Decision point: the holding flag is sampled as the stop bit begins.
      if (stop_entry) begin
        state_d = ST_STOP;
        if (pending) begin
          load    = 1'b1;
          chain_d = 1'b1;
        end else begin
          end_set = 1'b1;
        end
      end

      if (load) begin
        sh_d  = hold_data;
        par_d = par_calc;
        pen_d = par_en;
      end
    end
  end

  // Line value for the state being entered, registered for a clean output.
  always_comb begin
    unique case (state_d)
      ST_START:  out_d = 1'b0;
      ST_DATA:   out_d = sh_d[0];
      ST_PARITY: out_d = par_d;
      default:   out_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_MARK;
      cnt_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      pen_q   <= 1'b0;
      chain_q <= 1'b0;
      out_q   <= 1'b1;
    end else if (upd) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      pen_q   <= pen_d;
      chain_q <= chain_d;
      out_q   <= out_d;
    end
  end

  assign take   = load;
  assign tx_out = out_q;
endmodule

// File: rtl/dbtx_irq.sv
module dbtx_irq (
  input  logic hold_empty,
  input  logic tx_done,
  input  logic txi_en,
  input  logic tei_en,
  output logic irq_empty,
  output logic irq_done
);
  assign irq_empty = hold_empty & txi_en;
  assign irq_done  = tx_done & tei_en;
endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              txi_en,
  input  logic              tei_en,
  input  logic              baud_tick,
  output logic              tx_out,
  output logic              hold_empty,
  output logic              tx_done,
  output logic              irq_empty,
  output logic              irq_done
);
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              end_set;

  dbtx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .take       (take),
    .end_set    (end_set),
    .hold_data  (hold_data),
    .hold_empty (hold_empty),
    .tx_done    (tx_done)
  );

  dbtx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .baud_tick (baud_tick),
    .pending   (~hold_empty),
    .hold_data (hold_data),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .take      (take),
    .end_set   (end_set),
    .tx_out    (tx_out)
  );

  dbtx_irq u_irq (
    .hold_empty (hold_empty),
    .tx_done    (tx_done),
    .txi_en     (txi_en),
    .tei_en     (tei_en),
    .irq_empty  (irq_empty),
    .irq_done   (irq_done)
  );
endmodule

// File: rtl/dbtx_checker.sv
module dbtx_checker (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic wr_en,
  input logic baud_tick,
  input logic txi_en,
  input logic tei_en,
  input logic tx_out,
  input logic hold_empty,
  input logic tx_done,
  input logic irq_empty,
  input logic irq_done
);
  assert_disabled_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tx_out && hold_empty && tx_done));

  assert_write_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_en) |=> (!hold_empty && !tx_done));

  assert_line_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_out) |-> ($past(baud_tick) || !$past(en)));

  assert_load_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> ($past(baud_tick) || !$past(en)));

  assert_end_on_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> tx_out);

  assert_empty_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $rose(hold_empty) && txi_en) |-> irq_empty);

  assert_done_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_done) |-> (tx_done && tei_en));

  assert_overwrite_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_en && !hold_empty) |=> !hold_empty);

  assert_abort_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |=> tx_out);
endmodule

bind dbuf_serial_tx dbtx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .wr_en      (wr_en),
  .baud_tick  (baud_tick),
  .txi_en     (txi_en),
  .tei_en     (tei_en),
  .tx_out     (tx_out),
  .hold_empty (hold_empty),
  .tx_done    (tx_done),
  .irq_empty  (irq_empty),
  .irq_done   (irq_done)
);

// File: tb/dbuf_serial_tx_bench.sv
`timescale 1ns/1ps
module dbuf_serial_tx_bench;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       txi_en = 1'b0;
  logic       tei_en = 1'b0;
  logic       baud_tick = 1'b0;
  logic       tx_out, hold_empty, tx_done, irq_empty, irq_done;

  dbuf_serial_tx u_dbuf_serial_tx (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_data(wr_data),
    .par_en(par_en), .par_odd(par_odd), .txi_en(txi_en), .tei_en(tei_en),
    .baud_tick(baud_tick), .tx_out(tx_out), .hold_empty(hold_empty),
    .tx_done(tx_done), .irq_empty(irq_empty), .irq_done(irq_done)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [7:0] data;
    logic       pen;
    logic       podd;
    logic       chained;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails = 0;
  bit   mon_on = 1'b1;
  bit   test_done = 1'b0;
  int   frames_seen = 0;

  // Decoder state
  int         dstate = 0;
  int         pos = 0;
  int         idle_cnt = 99;
  int         gap = 0;
  logic [7:0] rx = 8'h00;
  exp_t       cur;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: one call per bit period with the line value just started.
  task automatic decode(input logic b);
    if (!mon_on || !en) begin
      dstate = 0;
      idle_cnt = 99;
      return;
    end
    case (dstate)
      0: begin
        if (b == 1'b0) begin
          gap = idle_cnt;
          if (q.size() == 0) begin
            check(1'b0, "R3", "start bit with no frame expected", 0, 1);
          end else begin
            cur = q[0];
            dstate = 1;
            pos = 0;
            rx = 8'h00;
          end
        end else begin
          idle_cnt++;
        end
      end
      1: begin
        rx[pos] = b;
        pos++;
        if (pos == 8) dstate = cur.pen ? 2 : 3;
      end
      2: begin
        check(b == (^cur.data ^ cur.podd), "R5", "parity bit",
              int'(b), int'(^cur.data ^ cur.podd));
        dstate = 3;
      end
      default: begin
        check(b == 1'b1, "R3", "stop bit", int'(b), 1);
        check(rx == cur.data, "R3", "received data", int'(rx), int'(cur.data));
        if (cur.chained)
          check(gap == 0, "R6", "idle bits before chained frame", gap, 0);
        void'(q.pop_front());
        frames_seen++;
        dstate = 0;
        idle_cnt = 0;
      end
    endcase
  endtask

  // Tick generator and monitor sampling share one process.
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (baud_tick) decode(tx_out);
      baud_tick = (cnt == DIV - 1);
      cnt = (cnt + 1) % DIV;
    end
  end

  task automatic write_byte(input logic [7:0] b, input bit chained,
                            input bit ovw, input bit push);
    exp_t it;
    it.data = b;
    it.pen = par_en;
    it.podd = par_odd;
    it.chained = chained;
    @(negedge clk);
    wr_data = b;
    wr_en = 1'b1;
    if (en && push) begin
      if (ovw) q[q.size()-1] = it;
      else     q.push_back(it);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (hold_empty) break;
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      if (tx_done) break;
    end
    repeat (3 * DIV) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!test_done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    // Reset state (R1, R8)
    repeat (4) @(negedge clk);
    check(tx_out == 1'b1, "R1", "tx_out in reset", int'(tx_out), 1);
    check(hold_empty == 1'b1, "R1", "hold_empty in reset", int'(hold_empty), 1);
    check(tx_done == 1'b1, "R1", "tx_done in reset", int'(tx_done), 1);
    check(irq_empty == 1'b0 && irq_done == 1'b0, "R8", "irqs with enables off",
          int'({irq_empty, irq_done}), 0);
    rst_n = 1'b1;

    // Write while disabled is ignored (R1)
    write_byte(8'h3C, 1'b0, 1'b0, 1'b0);
    repeat (10 * DIV) @(negedge clk);
    check(hold_empty == 1'b1, "R1", "hold_empty after disabled write", int'(hold_empty), 1);
    check(tx_done == 1'b1, "R1", "tx_done after disabled write", int'(tx_done), 1);
    en = 1'b1;
    repeat (14 * DIV) @(negedge clk);
    check(frames_seen == 0, "R1", "frames after disabled write", frames_seen, 0);
    check(tx_out == 1'b1, "R1", "line idle after enable", int'(tx_out), 1);

    // Single frame with interrupts (R2, R4, R7, R8)
    txi_en = 1'b1;
    tei_en = 1'b1;
    write_byte(8'hA5, 1'b0, 1'b0, 1'b1);
    check(hold_empty == 1'b0, "R2", "hold_empty after write", int'(hold_empty), 0);
    check(tx_done == 1'b0, "R2", "tx_done after write", int'(tx_done), 0);
    check(irq_empty == 1'b0 && irq_done == 1'b0, "R8", "irqs after write",
          int'({irq_empty, irq_done}), 0);
    wait_empty();
    check(hold_empty == 1'b1, "R4", "byte moved to shifter", int'(hold_empty), 1);
    check(irq_empty == 1'b1, "R8", "irq_empty on load", int'(irq_empty), 1);
    check(tx_done == 1'b0, "R7", "tx_done during frame", int'(tx_done), 0);
    wait_done();
    check(tx_done == 1'b1 && irq_done == 1'b1, "R7", "end flag and irq",
          int'({tx_done, irq_done}), 3);
    check(frames_seen == 1, "R3", "frames after single write", frames_seen, 1);
    repeat (6 * DIV) @(negedge clk);
    check(tx_out == 1'b1 && frames_seen == 1, "R7", "mark state after end",
          int'(tx_out), 1);

    // Chained frames (R6, R8)
    tei_en = 1'b0;
    txi_en = 1'b0;
    write_byte(8'h31, 1'b0, 1'b0, 1'b1);
    wait_empty();
    check(irq_empty == 1'b0, "R8", "irq_empty masked", int'(irq_empty), 0);
    write_byte(8'hC8, 1'b1, 1'b0, 1'b1);
    wait_empty();
    check(tx_done == 1'b0, "R6", "tx_done stays low across chain", int'(tx_done), 0);
    write_byte(8'h7E, 1'b1, 1'b0, 1'b1);
    wait_empty();
    check(tx_done == 1'b0, "R6", "tx_done stays low second chain", int'(tx_done), 0);
    wait_done();
    check(tx_done == 1'b1 && irq_done == 1'b0, "R8", "irq_done masked",
          int'({tx_done, irq_done}), 2);
    check(frames_seen == 4 && q.size() == 0, "R6", "chained frame count", frames_seen, 4);

    // Parity modes (R5)
    par_en = 1'b1;
    par_odd = 1'b0;
    write_byte(8'h96, 1'b0, 1'b0, 1'b1);
    wait_done();
    par_odd = 1'b1;
    write_byte(8'h96, 1'b0, 1'b0, 1'b1);
    wait_done();
    par_odd = 1'b0;
    write_byte(8'h07, 1'b0, 1'b0, 1'b1);
    wait_done();
    // Settings are captured at load time (R5)
    par_odd = 1'b1;
    write_byte(8'h5A, 1'b0, 1'b0, 1'b1);
    wait_empty();
    par_en = 1'b0;
    par_odd = 1'b0;
    wait_done();
    check(frames_seen == 8 && q.size() == 0, "R5", "parity frame count", frames_seen, 8);

    // Overwrite a pending byte (R9)
    write_byte(8'h11, 1'b0, 1'b0, 1'b1);
    wait_empty();
    write_byte(8'h22, 1'b1, 1'b0, 1'b1);
    check(hold_empty == 1'b0, "R9", "pending after first write", int'(hold_empty), 0);
    write_byte(8'h33, 1'b1, 1'b1, 1'b1);
    check(hold_empty == 1'b0, "R9", "pending after overwrite", int'(hold_empty), 0);
    wait_done();
    check(frames_seen == 10 && q.size() == 0, "R9", "overwrite frame count", frames_seen, 10);

    // Abort mid-frame (R10)
    mon_on = 1'b0;
    write_byte(8'hF0, 1'b0, 1'b0, 1'b0);
    wait_empty();
    write_byte(8'h0F, 1'b0, 1'b0, 1'b0);
    repeat (3 * DIV) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(tx_out == 1'b1, "R10", "line after abort", int'(tx_out), 1);
    check(hold_empty == 1'b1 && tx_done == 1'b1, "R10", "flags after abort",
          int'({hold_empty, tx_done}), 3);
    repeat (3 * DIV) @(negedge clk);
    en = 1'b1;
    mon_on = 1'b1;
    repeat (14 * DIV) @(negedge clk);
    check(tx_out == 1'b1 && hold_empty == 1'b1, "R10", "pending byte discarded",
          int'({tx_out, hold_empty}), 3);
    write_byte(8'h81, 1'b0, 1'b0, 1'b1);
    wait_done();
    check(frames_seen == 11 && q.size() == 0, "R10", "frame after recovery", frames_seen, 11);

    test_done = 1'b1;
    summary();
    $finish;
  end
endmodule